// File: doc/BRIEF.md
# Unsigned fixed-point reciprocal estimator

This block produces a coarse reciprocal of an unsigned 32-bit fraction. The operand is read as a value in [0, 1) with the binary point just above bit 31. When the operand is normalised (at least one half), its eight bits below the leading one select one of 256 precomputed 8-bit estimates. The result is packed into a 32-bit fixed-point word whose leading bit is always one. Operands below one half have no usable estimate and saturate to all ones.

The table holds a rounded reciprocal of the midpoint of each input interval. It is built at elaboration from a closed-form integer expression, so no literal table appears in the source. An optional output register gives one cycle of latency, with the valid flag kept in step with the data. Nothing flows back to the sender: a new operand can be presented on every cycle.

Top module: `recip_fx_est`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is 0 and `out_data` is 0x00000000.
- R2: With the default register stage, `out_valid` equals `in_valid` from the previous clock edge, and `out_data` belongs to the operand that was accepted on that edge.
- R3: An accepted operand whose bit 31 is 0 gives `out_data` = 0xFFFFFFFF.
- R4: An accepted operand whose bit 31 is 1 gives `out_data` bit 31 = 1.
- R5: For an operand whose bit 31 is 1, let idx = operand bits 30:23 and q = 256 + idx. Then `out_data` bits 30:23 equal the low eight bits of s, where s = floor(256 * 512 / (q + 0.5) + 0.5). s always lies in 256..511.
- R6: For an operand whose bit 31 is 1, `out_data` bits 22:0 are 0, and operand bits 22:0 have no effect on the result.
- R7: In a cycle that follows an edge where `in_valid` was 0, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand is present this cycle |
| in_data | input | 32 | Unsigned fraction, binary point above bit 31 |
| out_valid | output | 1 | Result is present |
| out_data | output | 32 | Reciprocal estimate, or all ones on saturation |

## Verification
The bench uses the defaults: a 32-bit word, an 8-bit index and the output register enabled. With these values all 256 table entries can be reached, so the sweep covers the whole table. Each entry is driven with random low bits to show that those bits are ignored. The smallest operand (0x80000000, largest estimate 511) and the largest (0xFFFFFFFF, smallest estimate 256) sit at the two ends of the table. The words 0x00000000 and 0x7FFFFFFF test saturation just below the one-half limit. Idle gaps between operands test that the output holds its value.

// File: rtl/recip_fx_est.sv
module recip_fx_est #(
  parameter int W       = 32,
  parameter int IDX_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int N  = 1 << IDX_W;
  localparam int SH = W - 1 - IDX_W;

  function automatic logic [IDX_W-1:0] est(input int i);
    longint d, s;
    d = 2 * (N + i) + 1;
    s = (8 * longint'(N) * N + d) / (2 * d);
    return s[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0] rom [N];
  for (genvar g = 0; g < N; g++) begin : g_rom
    assign rom[g] = est(g);
  end

  logic [IDX_W-1:0] idx;
  logic [W-1:0]     res;
  assign idx = in_data[W-2 -: IDX_W];
  assign res = in_data[W-1] ? {1'b1, rom[idx], {SH{1'b0}}} : '1;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        out_data  <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) out_data <= res;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_data  = res;
  end
endmodule

module recip_fx_est_chk #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic [W-1:0] out_data
);
  if (OUT_REG) begin : g_seq
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));
    // R3
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_data[W-1]) |=> (out_data == '1));
    // R4
    lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data[W-1]) |=> out_data[W-1]);
    // R6
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data[W-1]) |=> (out_data[W-10:0] == '0));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));
  end else begin : g_comb
    // R4
    lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && in_data[W-1]) |-> out_data[W-1]);
    // R3
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !in_data[W-1]) |-> (out_data == '1));
  end
endmodule

bind recip_fx_est recip_fx_est_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/recip_fx_est_test.sv
module recip_fx_est_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  logic [31:0] last_out = '0;
  bit          done = 1'b0;

  recip_fx_est uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] a);
    real r;
    int  s;
    if (!a[31]) return 32'hFFFFFFFF;
    r = 512.0 / (real'(256 + int'(a[30:23])) + 0.5);
    s = $rtoi(256.0 * r + 0.5);
    return {1'b1, s[7:0], 23'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = a;
    exp_q.push_back(model(a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = $urandom;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected valid", {31'b0, out_valid}, 32'd0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          if (!e[31] || e == 32'hFFFFFFFF)
            check("R3/R5 result", out_data, e);
          else
            check("R4/R5/R6 result", out_data, e);
        end
      end else begin
        check("R7 hold when idle", out_data, last_out);
      end
      last_out = out_data;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'b0, out_valid}, 32'd0);
    check("R1 reset data", out_data, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle valid", {31'b0, out_valid}, 32'd0);
    check("R1 first cycle data", out_data, 32'd0);
    // R5 R6: full index sweep with random low bits
    for (int i = 0; i < 256; i++)
      drive({1'b1, i[7:0], 23'($urandom)});
    idle(3);
    // R3: saturation boundaries
    drive(32'h00000000);
    drive(32'h7FFFFFFF);
    idle(2);
    // R5: table ends
    drive(32'h80000000);
    idle(1);
    drive(32'hFFFFFFFF);
    idle(2);
    for (int i = 0; i < 64; i++) begin
      drive($urandom);
      if (i % 5 == 0) idle(1 + i % 3);
    end
    idle(4);
    check("R2 all results seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule